// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block turns 16-bit stereo PCM sample pairs from a decoder core into a three-wire serial audio stream. The three wires are a channel clock, a bit clock and serial data. It runs from the 16.9344 MHz master clock used at normal playback speed. The bit clock is the master clock divided by 12, giving 1.4112 MHz. The channel clock is the master clock divided by 384, giving 44.1 kHz. Each stereo frame therefore spans 32 bit clocks: a 16-bit left slot followed by a 16-bit right slot.

The core offers a sample pair with a valid strike. The block raises its request for exactly one master cycle just before every frame start, and takes the pair if it is valid in that cycle. If no pair is offered, the last accepted pair is sent again and an underrun indication is raised for that frame. At each frame start the block also samples two controls:
- a channel-clock polarity control;
- a two-bit channel-routing control. It can send stereo, copy one channel into both slots (for bilingual discs), or mute.

An emphasis flag output follows the decoder's emphasis bit, with a polarity control of its own.

Top module: `aud_ser_tx`

## Requirements
- R1: The bit clock has a period of 12 master cycles: 6 cycles high, then 6 cycles low. The channel clock has a period of 384 master cycles, which is 32 bit clocks.
- R2: With `lr_inv_i`=0 the channel clock is low for the whole left slot and high for the whole right slot. With `lr_inv_i`=1 both levels are inverted. The polarity is taken in the request cycle and holds for the whole frame.
- R3: Each slot carries a 16-bit two's-complement sample, MSB first, with the left slot first. Serial data and the channel clock change only on the master edge at which the bit clock rises.
- R4: Routing code 2'b00 (stereo) sends the left sample in the left slot and the right sample in the right slot.
- R5: Routing code 2'b01 sends the left sample in both slots. Code 2'b10 sends the right sample in both slots. Code 2'b11 sends zeros in both slots. The code is taken in the request cycle.
- R6: `smp_req_o` is high for exactly one master cycle per frame, in the cycle just before the left slot starts. A pair with `smp_valid_i` high in that cycle is the one sent in the next frame.
- R7: If `smp_valid_i` is low in the request cycle, the previously accepted pair is sent again. `underrun_o` is high for that frame and low in any frame whose pair was accepted.
- R8: `emph_o` equals `emph_i` XOR `emph_inv_i`, registered with one master cycle of latency.
- R9: While `rst` is high, the outputs hold these values: channel clock 0, bit clock 0, data 0, `smp_req_o` 1, `underrun_o` 0 and `emph_o` 0. The first frame starts on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (16.9344 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample pair on `smp_left_i`/`smp_right_i` is valid |
| smp_left_i | input | 16 | Left channel sample, two's complement |
| smp_right_i | input | 16 | Right channel sample, two's complement |
| smp_req_o | output | 1 | Request/accept cycle for the next pair |
| mix_mode_i | input | 2 | Routing: 00 stereo, 01 left both, 10 right both, 11 mute |
| lr_inv_i | input | 1 | Invert channel-clock polarity |
| emph_i | input | 1 | Emphasis state from the decoder (1 = on) |
| emph_inv_i | input | 1 | Invert emphasis flag polarity |
| lrck_o | output | 1 | Channel clock |
| bclk_o | output | 1 | Bit clock |
| sdata_o | output | 1 | Serial audio data |
| emph_o | output | 1 | Emphasis flag |
| underrun_o | output | 1 | Current frame repeats the previous pair |

## Verification
The assertions assume a few things about the block's inputs. Reset must be held across at least one clock edge. Every input must be settled at the master edge where it is sampled, so that edges are the only points where data, channel clock and request can move. The stimulus changes every input on the falling master edge. It presents a new pair, routing code and polarity only while the request is high, then drops the valid strike. This keeps the handshake and the per-frame control sampling within the one-cycle window that the properties relate.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [1:0] {
    MIX_STEREO = 2'b00,
    MIX_LEFT   = 2'b01,
    MIX_RIGHT  = 2'b10,
    MIX_MUTE   = 2'b11
  } mix_e;

endpackage

// File: rtl/aud_ser_clkgen.sv
module aud_ser_clkgen #(
  parameter int BCLK_DIV  = 12,
  parameter int SLOT_BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lr_inv_i,
  output logic bclk_o,
  output logic lrck_o,
  output logic req_o,
  output logic bit_adv_o
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int DW = $clog2(BCLK_DIV);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [DW-1:0] DIV_LAST = DW'(BCLK_DIV - 1);
  localparam logic [DW-1:0] DIV_HALF = DW'(BCLK_DIV / 2);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] SLOT_B   = BW'(SLOT_BITS);

  logic [DW-1:0] div_q, div_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          inv_q, inv_n;

  always_comb begin
    div_n = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    bit_n = bit_q;
    if (div_q == DIV_LAST)
      bit_n = (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
    inv_n = req_o ? lr_inv_i : inv_q;
  end

  assign bit_adv_o = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= DIV_LAST;
      bit_q  <= BIT_LAST;
      inv_q  <= 1'b0;
      bclk_o <= 1'b0;
      lrck_o <= 1'b0;
      req_o  <= 1'b1;
    end else begin
      div_q  <= div_n;
      bit_q  <= bit_n;
      inv_q  <= inv_n;
      bclk_o <= (div_n < DIV_HALF);
      lrck_o <= (bit_n >= SLOT_B) ^ inv_n;
      req_o  <= (div_n == DIV_LAST) && (bit_n == BIT_LAST);
    end
  end

  AST_BCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_o) |=> bclk_o); // R1
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o); // R6
  AST_REQ_AT_BIT_END: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (bit_adv_o && !bclk_o)); // R6
endmodule

// File: rtl/aud_ser_pair.sv
module aud_ser_pair #(
  parameter int SLOT_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take_i,
  input  logic                   valid_i,
  input  logic [SLOT_BITS-1:0]   left_i,
  input  logic [SLOT_BITS-1:0]   right_i,
  input  logic [1:0]             mode_i,
  output logic [2*SLOT_BITS-1:0] word_o,
  output logic                   underrun_o
);
  import aud_ser_pkg::*;

  logic [SLOT_BITS-1:0] held_l, held_r, src_l, src_r;
  logic                 accept;
  mix_e                 mode;

  assign accept = take_i && valid_i;
  assign src_l  = accept ? left_i  : held_l;
  assign src_r  = accept ? right_i : held_r;
  assign mode   = mix_e'(mode_i);

  always_comb begin
    case (mode)
      MIX_STEREO: word_o = {src_l, src_r};
      MIX_LEFT:   word_o = {src_l, src_l};
      MIX_RIGHT:  word_o = {src_r, src_r};
      default:    word_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_l     <= '0;
      held_r     <= '0;
      underrun_o <= 1'b0;
    end else if (take_i) begin
      held_l     <= src_l;
      held_r     <= src_r;
      underrun_o <= !valid_i;
    end
  end

  AST_HELD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (take_i && !valid_i) |=> ($stable(held_l) && $stable(held_r))); // R7
  AST_UNDERRUN_STEADY: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(underrun_o)); // R7
endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift #(
  parameter int SLOT_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_adv_i,
  input  logic                   load_i,
  input  logic [2*SLOT_BITS-1:0] word_i,
  output logic                   sdata_o
);
  localparam int WW = 2 * SLOT_BITS;

  logic [WW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      sdata_o <= 1'b0;
    end else if (bit_adv_i) begin
      if (load_i) begin
        sdata_o <= word_i[WW-1];
        sh_q    <= {word_i[WW-2:0], 1'b0};
      end else begin
        sdata_o <= sh_q[WW-1];
        sh_q    <= {sh_q[WW-2:0], 1'b0};
      end
    end
  end

  AST_DATA_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    !bit_adv_i |=> $stable(sdata_o)); // R3
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int BCLK_DIV  = 12,
  parameter int SLOT_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid_i,
  input  logic [SLOT_BITS-1:0] smp_left_i,
  input  logic [SLOT_BITS-1:0] smp_right_i,
  output logic                 smp_req_o,
  input  logic [1:0]           mix_mode_i,
  input  logic                 lr_inv_i,
  input  logic                 emph_i,
  input  logic                 emph_inv_i,
  output logic                 lrck_o,
  output logic                 bclk_o,
  output logic                 sdata_o,
  output logic                 emph_o,
  output logic                 underrun_o
);
  localparam int WW = 2 * SLOT_BITS;

  logic          bit_adv;
  logic [WW-1:0] word;

  aud_ser_clkgen #(.BCLK_DIV(BCLK_DIV), .SLOT_BITS(SLOT_BITS)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .lr_inv_i  (lr_inv_i),
    .bclk_o    (bclk_o),
    .lrck_o    (lrck_o),
    .req_o     (smp_req_o),
    .bit_adv_o (bit_adv)
  );

  aud_ser_pair #(.SLOT_BITS(SLOT_BITS)) u_pair (
    .clk        (clk),
    .rst        (rst),
    .take_i     (smp_req_o),
    .valid_i    (smp_valid_i),
    .left_i     (smp_left_i),
    .right_i    (smp_right_i),
    .mode_i     (mix_mode_i),
    .word_o     (word),
    .underrun_o (underrun_o)
  );

  aud_ser_shift #(.SLOT_BITS(SLOT_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_adv_i (bit_adv),
    .load_i    (smp_req_o),
    .word_i    (word),
    .sdata_o   (sdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) emph_o <= 1'b0;
    else     emph_o <= emph_i ^ emph_inv_i;
  end

  AST_DATA_WITH_BCLK: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> $rose(bclk_o)); // R3
  AST_LRCK_WITH_BCLK: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_o) |-> $rose(bclk_o)); // R3
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (smp_req_o && !smp_valid_i) |=> underrun_o); // R7
  AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (smp_req_o && smp_valid_i) |=> !underrun_o); // R7
  AST_FRAME_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    smp_req_o |=> bclk_o); // R6
endmodule

// File: tb/test_aud_ser_tx.sv
module test_aud_ser_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_left_i = '0, smp_right_i = '0;
  logic [1:0]  mix_mode_i = 2'b00;
  logic        lr_inv_i = 1'b0, emph_i = 1'b0, emph_inv_i = 1'b0;
  logic        smp_req_o, lrck_o, bclk_o, sdata_o, emph_o, underrun_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  aud_ser_tx i_aud_ser_tx (.*);

  // vector: mode[68:67] inv[66] valid[65] L[64:49] R[48:33] exp_word[32:1] exp_und[0]
  localparam int NV = 7;
  localparam logic [68:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b1, 16'h8001, 16'h7FFE, 32'h8001_7FFE, 1'b0},
    {2'b00, 1'b1, 1'b1, 16'hA5C3, 16'h0F0F, 32'hA5C3_0F0F, 1'b0},
    {2'b01, 1'b0, 1'b1, 16'h1234, 16'hABCD, 32'h1234_1234, 1'b0},
    {2'b10, 1'b0, 1'b1, 16'hFFFF, 16'h0001, 32'h0001_0001, 1'b0},
    {2'b11, 1'b0, 1'b1, 16'h5555, 16'hAAAA, 32'h0000_0000, 1'b0},
    {2'b00, 1'b0, 1'b0, 16'hDEAD, 16'hBEEF, 32'h5555_AAAA, 1'b1},
    {2'b00, 1'b1, 1'b1, 16'h0000, 16'h8000, 32'h0000_8000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] m, input logic inv, input logic v,
                           input logic [15:0] l, input logic [15:0] r,
                           output logic [31:0] w, output int lr_err,
                           output int ck_err, output logic und);
    lr_err = 0; ck_err = 0; w = '0;
    while (!smp_req_o) @(negedge clk);
    mix_mode_i = m; lr_inv_i = inv; smp_valid_i = v;
    smp_left_i = l; smp_right_i = r;
    @(negedge clk);
    smp_valid_i = 1'b0;
    smp_left_i = '0; smp_right_i = '0;
    und = underrun_o;
    for (int i = 0; i < 32; i++) begin
      if (i > 0) repeat (12) @(negedge clk);
      w[31-i] = sdata_o;
      if (lrck_o !== ((i < 16) ? inv : ~inv)) lr_err++;
      if (bclk_o !== 1'b1) ck_err++;
    end
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int lr_err, ck_err, rises, highs, lr_rises, reqs;
    logic und, pb, pl;

    emph_i = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 reset outs {lrck,bclk,sdata,req,und,emph}",
        {26'd0, lrck_o, bclk_o, sdata_o, smp_req_o, underrun_o, emph_o},
        {26'd0, 6'b000100});
    emph_i = 1'b0;
    rst = 1'b0;

    // table-driven frames: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      run_frame(VEC[k][68:67], VEC[k][66], VEC[k][65], VEC[k][64:49], VEC[k][48:33],
                w, lr_err, ck_err, und);
      chk($sformatf("R3/R4/R5/R7 frame %0d word", k), w, VEC[k][32:1]);
      chk($sformatf("R2 frame %0d lrck level errors", k), lr_err, 0);
      chk($sformatf("R3 frame %0d bclk high at bit centre errors", k), ck_err, 0);
      chk($sformatf("R7 frame %0d underrun", k), {31'd0, und}, {31'd0, VEC[k][0]});
    end

    // R1 / R6: clock periods and request count over two frames
    while (!smp_req_o) @(negedge clk);
    mix_mode_i = 2'b00; lr_inv_i = 1'b0; smp_valid_i = 1'b1;
    smp_left_i = 16'h0F0F; smp_right_i = 16'hF0F0;
    @(negedge clk);
    smp_valid_i = 1'b0;
    rises = 0; highs = 0; lr_rises = 0; reqs = 0;
    pb = bclk_o; pl = lrck_o;
    for (int c = 0; c < 768; c++) begin
      @(negedge clk);
      if (bclk_o && !pb) rises++;
      if (bclk_o) highs++;
      if (lrck_o && !pl) lr_rises++;
      if (smp_req_o) reqs++;
      pb = bclk_o; pl = lrck_o;
    end
    chk("R1 bclk rises in 768 cycles", rises, 64);
    chk("R1 bclk high cycles in 768 cycles", highs, 384);
    chk("R1 lrck rises in 768 cycles", lr_rises, 2);
    chk("R6 request cycles in 768 cycles", reqs, 2);
    // R7: the frame without a valid strike repeats the last pair
    run_frame(2'b00, 1'b0, 1'b0, 16'h1111, 16'h2222, w, lr_err, ck_err, und);
    chk("R7 repeated pair after missed request", w, 32'h0F0F_F0F0);

    // R8: emphasis flag polarity
    for (int e = 0; e < 4; e++) begin
      emph_i = e[0]; emph_inv_i = e[1];
      @(negedge clk);
      chk($sformatf("R8 emph in=%0d inv=%0d", e[0], e[1]), {31'd0, emph_o},
          {31'd0, e[0] ^ e[1]});
    end

    // R9: reset mid-stream
    rst = 1'b1;
    emph_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset mid-stream outs", {26'd0, lrck_o, bclk_o, sdata_o, smp_req_o,
        underrun_o, emph_o}, {26'd0, 6'b000100});
    rst = 1'b0;
    emph_i = 1'b0; emph_inv_i = 1'b0;
    run_frame(2'b10, 1'b1, 1'b1, 16'h0000, 16'hC3A5, w, lr_err, ck_err, und);
    chk("R9 first frame after reset word", w, 32'hC3A5_C3A5);
    chk("R9/R2 first frame after reset lrck errors", lr_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule